// File: doc/BRIEF.md
# Three-Wire Serial Control Word Loader

This block receives a frequency-synthesiser control word over a three-wire serial bus made of a data line, a bus clock and an enable strobe. Bits are taken only while the enable strobe is high. One word carries a divisor value followed by four general-purpose port bits. The block runs on a fast system clock. All three bus lines pass through synchronisers, and their edges are found in the system-clock domain.

The word is double-buffered. Bits go into a shift register while the strobe is high. The holding registers that drive the outputs load only when the strobe falls, and only if the number of bits received matches the word length that the current mode expects. A word with the wrong bit count is dropped, and the outputs keep their old values. The 2-bit mode input sets the divisor width. Mode 3 uses a 14-bit divisor and an 18-bit word. Every other mode uses a 15-bit divisor and a 19-bit word. The port bits come out as active-low enables for open-collector style sinks.

Top module: `tw_ctrl_loader`

## Requirements
- R1: After reset, `divisor_o` is 0 and every bit of `port_oe_n_o` is 1 (all sinks off).
- R2: A bit is taken on a rising edge of `bus_clk_i` only while `bus_en_i` is high. Bus clock edges while the strobe is low change neither the outputs nor the next accepted word. A rising strobe restarts the bit count.
- R3: In mode 3 a word is 18 bits, sent MSB first: 14 divisor bits, then 4 port bits. The loaded `divisor_o[14]` is 0.
- R4: In modes 0, 1 and 2 a word is 19 bits, sent MSB first: 15 divisor bits, then 4 port bits.
- R5: The outputs never change while the strobe is high. An accepted word appears on the third rising system-clock edge after the strobe goes low.
- R6: If the strobe falls after a bit count that differs from the mode's word length, the word is dropped and both outputs keep their previous values.
- R7: `port_oe_n_o[i]` is 0 when its port bit was 1 and 1 when its port bit was 0. The first port bit sent maps to index 3 and the last to index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Serial bus clock, asynchronous |
| bus_data_i | input | 1 | Serial bus data, asynchronous |
| bus_en_i | input | 1 | Serial bus enable strobe, asynchronous |
| mode_i | input | 2 | Word-length mode; 3 selects the short word |
| divisor_o | output | 15 | Held divisor word |
| port_oe_n_o | output | 4 | Active-low sink enables for the four ports |

## Verification
The bench drops words whose length is one bit too long in mode 3 or one bit too short in mode 1, and sends an empty strobe pulse. A design that checked only a lower bound on the count would load a shifted value in these cases. It toggles the bus clock with the strobe low, which would corrupt the next word if the clock gating failed. It loads a short word after a long one whose leftover top bit is 1, which would show up on `divisor_o[14]` if the divisor were not masked. It counts cycles after the falling strobe and compares the outputs on every clock against a behavioural model. This catches outputs that leak mid-frame or that load one cycle early or late.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
    localparam int unsigned DIV_W  = 15;
    localparam int unsigned PORT_W = 4;
    localparam int unsigned WORD_W = DIV_W + PORT_W;
    localparam int unsigned CNT_W  = $clog2(WORD_W + 2);
    localparam logic [1:0]  MODE_SHORT = 2'd3;
endpackage

// File: rtl/tw_sync.sv
`timescale 1ns/1ps
module tw_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.chain[0] = async_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            sync_d.chain[i] = sync_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q.chain[STAGES-1];
endmodule

// File: rtl/tw_shift.sv
`timescale 1ns/1ps
module tw_shift #(
    parameter int unsigned WORD_W = tw_pkg::WORD_W,
    parameter int unsigned CNT_W  = tw_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              bclk_i,
    input  logic              data_i,
    output logic [WORD_W-1:0] word_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              fall_o
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
        logic              en_prev;
        logic              clk_prev;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d          = sh_q;
        sh_d.en_prev  = en_i;
        sh_d.clk_prev = bclk_i;
        if (en_i && !sh_q.en_prev) begin
            sh_d.cnt = '0;
        end else if (en_i && bclk_i && !sh_q.clk_prev) begin
            sh_d.word = {sh_q.word[WORD_W-2:0], data_i};
            if (sh_q.cnt != '1) sh_d.cnt = sh_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign word_o = sh_q.word;
    assign cnt_o  = sh_q.cnt;
    assign fall_o = sh_q.en_prev & ~en_i;

    // R2
    gated_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(sh_q.word));
    // R2
    count_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !sh_q.en_prev) |=> (sh_q.cnt == '0));
endmodule

// File: rtl/tw_hold.sv
`timescale 1ns/1ps
module tw_hold #(
    parameter int unsigned DIV_W  = tw_pkg::DIV_W,
    parameter int unsigned PORT_W = tw_pkg::PORT_W,
    parameter int unsigned WORD_W = tw_pkg::WORD_W,
    parameter int unsigned CNT_W  = tw_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [1:0]        mode_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [DIV_W-1:0]  div_o,
    output logic [PORT_W-1:0] oe_n_o
);
    localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [PORT_W-1:0] ports;
    } hold_t;

    hold_t hd_d, hd_q;
    logic  short_mode;
    logic  len_ok;

    always_comb begin
        short_mode = (mode_i == tw_pkg::MODE_SHORT);
        len_ok     = short_mode ? (cnt_i == LEN_SHORT) : (cnt_i == LEN_LONG);
        hd_d       = hd_q;
        if (commit_i && len_ok) begin
            hd_d.ports = word_i[PORT_W-1:0];
            if (short_mode) hd_d.div = {1'b0, word_i[WORD_W-2:PORT_W]};
            else            hd_d.div = word_i[WORD_W-1:PORT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hd_q <= '0;
        else        hd_q <= hd_d;
    end

    assign div_o  = hd_q.div;
    assign oe_n_o = ~hd_q.ports;

    // R6
    bad_len_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && cnt_i != LEN_LONG && cnt_i != LEN_SHORT)
        |=> ($stable(hd_q.div) && $stable(hd_q.ports)));
    // R3
    short_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && mode_i == tw_pkg::MODE_SHORT && cnt_i == LEN_SHORT)
        |=> (hd_q.div[DIV_W-1] == 1'b0));
endmodule

// File: rtl/tw_ctrl_loader.sv
`timescale 1ns/1ps
module tw_ctrl_loader #(
    parameter int unsigned DIV_W       = tw_pkg::DIV_W,
    parameter int unsigned PORT_W      = tw_pkg::PORT_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_clk_i,
    input  logic              bus_data_i,
    input  logic              bus_en_i,
    input  logic [1:0]        mode_i,
    output logic [DIV_W-1:0]  divisor_o,
    output logic [PORT_W-1:0] port_oe_n_o
);
    localparam int unsigned WORD_W = DIV_W + PORT_W;
    localparam int unsigned CNT_W  = $clog2(WORD_W + 2);

    logic [2:0]        bus_s;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  cnt;
    logic              fall;

    tw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({bus_en_i, bus_clk_i, bus_data_i}),
        .sync_o(bus_s)
    );

    tw_shift #(.WORD_W(WORD_W), .CNT_W(CNT_W)) i_shift (
        .clk(clk), .rst_n(rst_n),
        .en_i(bus_s[2]), .bclk_i(bus_s[1]), .data_i(bus_s[0]),
        .word_o(word), .cnt_o(cnt), .fall_o(fall)
    );

    tw_hold #(.DIV_W(DIV_W), .PORT_W(PORT_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) i_hold (
        .clk(clk), .rst_n(rst_n),
        .commit_i(fall), .mode_i(mode_i), .word_i(word), .cnt_i(cnt),
        .div_o(divisor_o), .oe_n_o(port_oe_n_o)
    );

    // R5
    hold_while_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_s[2] |=> ($stable(divisor_o) && $stable(port_oe_n_o)));
endmodule

// File: tb/test_tw_ctrl_loader.sv
`timescale 1ns/1ps
module test_tw_ctrl_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_clk = 1'b0, bus_data = 1'b0, bus_en = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [14:0] divisor;
    logic [3:0]  oe_n;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tw_ctrl_loader i_tw_ctrl_loader (
        .clk(clk), .rst_n(rst_n), .bus_clk_i(bus_clk), .bus_data_i(bus_data),
        .bus_en_i(bus_en), .mode_i(mode), .divisor_o(divisor), .port_oe_n_o(oe_n)
    );

    // Behavioural reference model
    int   bits[$];
    int   m_div = 0, m_ports = 0, p_div = 0, p_ports = 0, cd = 0;
    bit   p_ok = 0;
    logic prev_en = 0, prev_bclk = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_ports = 0; cd = 0; p_ok = 0;
            prev_en = 0; prev_bclk = 0; bits.delete();
        end else begin
            if (cd > 0) begin
                cd--;
                if (cd == 0 && p_ok) begin m_div = p_div; m_ports = p_ports; end
            end
            if (bus_en && !prev_en) bits.delete();
            else if (bus_en && bus_clk && !prev_bclk) bits.push_back(int'(bus_data));
            if (!bus_en && prev_en) begin
                int n;
                n = (mode == 2'd3) ? 18 : 19;
                p_ok = (bits.size() == n);
                if (p_ok) begin
                    p_div = 0; p_ports = 0;
                    for (int i = 0; i < n - 4; i++) p_div = (p_div << 1) | bits[i];
                    for (int i = n - 4; i < n; i++) p_ports = (p_ports << 1) | bits[i];
                end
                cd = 2;
            end
            prev_en = bus_en; prev_bclk = bus_clk;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (divisor !== 15'(m_div) || oe_n !== ~4'(m_ports)) begin
                fails++;
                $display("FAIL R5 model compare: div=%h oe_n=%b expected div=%h oe_n=%b",
                         divisor, oe_n, 15'(m_div), ~4'(m_ports));
            end
        end
    end

    task automatic chk(input string rq, input logic [14:0] ed, input logic [3:0] eo);
        checks++;
        if (divisor !== ed || oe_n !== eo) begin
            fails++;
            $display("FAIL %s: div=%h oe_n=%b expected div=%h oe_n=%b", rq, divisor, oe_n, ed, eo);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        @(negedge clk) bus_data = b;
        wait_n(3); bus_clk = 1'b1;
        wait_n(3); bus_clk = 1'b0;
    endtask

    task automatic frame(input logic [18:0] w, input int n);
        @(negedge clk) bus_en = 1'b1;
        wait_n(3);
        for (int i = n - 1; i >= 0; i--) bit_out(w[i]);
        wait_n(3);
    endtask

    task automatic end_frame();
        @(negedge clk) bus_en = 1'b0;
        wait_n(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_n(5);
        chk("R1 reset state", 15'h0000, 4'b1111);
        @(negedge clk) rst_n = 1'b1;
        wait_n(4);

        // R4 / R5 / R7: mode 0 long word, exact latency
        mode = 2'd0;
        frame({15'h2A5C, 4'b1010}, 19);
        chk("R5 stable while enable high", 15'h0000, 4'b1111);
        @(negedge clk) bus_en = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        chk("R5 not yet loaded at 2nd edge", 15'h0000, 4'b1111);
        @(posedge clk); #1;
        chk("R4 R7 loaded at 3rd edge", 15'h2A5C, 4'b0101);
        wait_n(4);

        // R3: mode 3 short word
        mode = 2'd3;
        frame({1'b0, 14'h1234, 4'b0011}, 18);
        end_frame();
        chk("R3 short word", 15'h1234, 4'b1100);

        // R6: wrong lengths dropped
        frame({15'h7777, 4'b1111}, 19);
        end_frame();
        chk("R6 long word in mode 3 dropped", 15'h1234, 4'b1100);
        mode = 2'd1;
        frame({1'b0, 14'h0F0F, 4'b1111}, 18);
        end_frame();
        chk("R6 short word in mode 1 dropped", 15'h1234, 4'b1100);

        // R2: bus clocks with enable low ignored
        bus_data = 1'b1;
        for (int i = 0; i < 10; i++) begin
            wait_n(3); bus_clk = 1'b1; wait_n(3); bus_clk = 1'b0;
        end
        chk("R2 clocks with enable low ignored", 15'h1234, 4'b1100);
        mode = 2'd2;
        frame({15'h7FFF, 4'b0001}, 19);
        chk("R5 outputs held mid-word", 15'h1234, 4'b1100);
        end_frame();
        chk("R2 R4 R7 mode 2 word after stray clocks", 15'h7FFF, 4'b1110);

        // R6: empty strobe pulse
        @(negedge clk) bus_en = 1'b1;
        wait_n(4);
        end_frame();
        chk("R6 empty strobe dropped", 15'h7FFF, 4'b1110);

        // R3: short word after long one, top bit must clear
        mode = 2'd3;
        frame({1'b1, 14'h3FFF, 4'b1111}, 18);
        end_frame();
        chk("R3 R7 short word top bit cleared", 15'h3FFF, 4'b0000);

        // R1: reset mid-run
        @(negedge clk) rst_n = 1'b0;
        wait_n(2);
        chk("R1 reset clears held word", 15'h0000, 4'b1111);
        @(negedge clk) rst_n = 1'b1;
        wait_n(4);

        mode = 2'd0;
        frame({15'h0001, 4'b1000}, 19);
        end_frame();
        chk("R4 R7 minimum divisor", 15'h0001, 4'b0111);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule